// File: doc/BRIEF.md
# Two-Level Daisy-Chained Bus Arbiter

This block is a central bus arbiter that resolves contention in two stages. Devices are grouped onto priority levels. Each level has one shared request line, formed by ORing the requests of its devices, and one serial grant line. When the bus is free, the arbiter looks only at the level request lines and gives the grant to the highest-priority level that is asserting. Inside that level, the grant passes from device to device in chain order. The first device on the chain that is requesting keeps the grant, and every device after it receives nothing.

The level of each device and its position on its level's chain are fixed by parameters. Time-critical devices are placed on the upper levels. With the default map, level 0 carries devices 0 then 1, and level 1 carries devices 3, 2 and 4 in that chain order. The overall order is therefore 0 > 1 > 3 > 2 > 4. A device that wins keeps the bus for as long as it holds its request. The bus is arbitrated again only after it has been idle for one cycle.

Top module: `mlvl_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `dev_gnt` and `lvl_gnt` are all zero and `bus_busy` is 0.
- R2: When the bus is idle and at least one device requests at a rising clock edge, a grant appears on the outputs right after that edge.
- R3: If devices on more than one level request at once, only a device on the numerically lowest requesting level is granted, and level 0 is the top priority.
- R4: Among requesters on the winning level, the grant goes to the one with the lowest chain position. With the default map (device→level/position: 0→0/0, 1→0/1, 2→1/1, 3→1/0, 4→1/2), the overall order is 0 > 1 > 3 > 2 > 4.
- R5: At most one bit of `dev_gnt` and at most one bit of `lvl_gnt` is high. `lvl_gnt` has a bit set exactly when `dev_gnt` does. `bus_busy` equals the OR of `dev_gnt`.
- R6: While the owner keeps its request high, its grant stays unchanged. A new request from any other device is ignored, including one from a higher level.
- R7: When the owner drops its request at a clock edge, all grants clear after that edge. The next grant can appear no earlier than one clock later.
- R8: A newly issued grant always goes to a device whose request was high at the edge that issued it.
- R9: With the bus idle and no requests, no grant is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dev_req | input | N_DEV | Per-device bus request, bit d = device d |
| dev_gnt | output | N_DEV | Per-device bus grant, one-hot or zero |
| lvl_gnt | output | N_LVL | Grant line of the winning level, one-hot or zero |
| bus_busy | output | 1 | Bus is owned by a device |

## Verification
Two events can fall in the same cycle: the current owner releasing the bus, and requests waiting on several levels at once. The bench has a level-1 device hold the bus while level-0 and level-1 requests pile up behind it. The owner then drops its request while the others stay asserted. The expected result is one empty cycle, followed by a grant to the level-0 device, regardless of which level has been waiting longest. A second scenario checks that a higher-level request arriving during ownership leaves the owner's grant stable.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Width of one entry in the packed device map parameters
    localparam int unsigned MAP_FW = 8;

    typedef enum logic {
        OWN_IDLE  = 1'b0,
        OWN_HELD  = 1'b1
    } own_st_e;

endpackage

// File: rtl/mlvl_req_map.sv
// Gathers the per-device requests into one shared request line per level.
module mlvl_req_map
    import arb_pkg::*;
#(
    parameter int unsigned N_DEV = 5,
    parameter int unsigned N_LVL = 2,
    parameter logic [N_DEV*MAP_FW-1:0] DEV_LVL = '0
) (
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_LVL-1:0] lvl_req
);

    function automatic logic [N_DEV-1:0] level_mask(int lv);
        logic [N_DEV-1:0] m;
        m = '0;
        for (int d = 0; d < int'(N_DEV); d++) begin
            if (int'(DEV_LVL[d*MAP_FW +: MAP_FW]) == lv) m[d] = 1'b1;
        end
        return m;
    endfunction

    for (genvar l = 0; l < int'(N_LVL); l++) begin : g_lvl
        localparam logic [N_DEV-1:0] MASK = level_mask(l);
        assign lvl_req[l] = |(dev_req & MASK);
    end

endmodule

// File: rtl/mlvl_lvl_select.sv
// Fixed priority across levels: lowest index wins.
module mlvl_lvl_select #(
    parameter int unsigned N_LVL = 2
) (
    input  logic [N_LVL-1:0] lvl_req,
    output logic [N_LVL-1:0] lvl_win
);

    always_comb begin
        lvl_win = '0;
        for (int l = 0; l < int'(N_LVL); l++) begin
            if (lvl_req[l] && (lvl_win == '0)) lvl_win[l] = 1'b1;
        end
    end

endmodule

// File: rtl/mlvl_chain.sv
// Per-level serial grant ripple. The grant entering slot 0 of a level is
// that level's win bit; each slot either keeps it (device requesting) or
// hands it to the next slot. Empty slots pass the grant straight through.
module mlvl_chain
    import arb_pkg::*;
#(
    parameter int unsigned N_DEV = 5,
    parameter int unsigned N_LVL = 2,
    parameter logic [N_DEV*MAP_FW-1:0] DEV_LVL = '0,
    parameter logic [N_DEV*MAP_FW-1:0] DEV_POS = '0
) (
    input  logic [N_DEV-1:0] dev_req,
    input  logic [N_LVL-1:0] lvl_win,
    output logic [N_DEV-1:0] dev_pick
);

    // Which device sits at (level, position); N_DEV means empty slot
    function automatic int slot_owner(int lv, int ps);
        for (int d = 0; d < int'(N_DEV); d++) begin
            if (int'(DEV_LVL[d*MAP_FW +: MAP_FW]) == lv &&
                int'(DEV_POS[d*MAP_FW +: MAP_FW]) == ps) return d;
        end
        return int'(N_DEV);
    endfunction

    wire [N_DEV-1:0] ripple [N_LVL];
    wire [N_DEV-1:0] take   [N_LVL];
    wire [N_DEV-1:0] pick_w;

    for (genvar l = 0; l < int'(N_LVL); l++) begin : g_lvl
        assign ripple[l][0] = lvl_win[l];
        for (genvar s = 0; s < int'(N_DEV); s++) begin : g_slot
            localparam int DV = slot_owner(l, s);
            if (DV < int'(N_DEV)) begin : g_used
                assign take[l][s] = ripple[l][s] & dev_req[DV];
                if (s < int'(N_DEV) - 1) begin : g_pass
                    assign ripple[l][s+1] = ripple[l][s] & ~dev_req[DV];
                end
            end else begin : g_empty
                assign take[l][s] = 1'b0;
                if (s < int'(N_DEV) - 1) begin : g_pass
                    assign ripple[l][s+1] = ripple[l][s];
                end
            end
        end
    end

    for (genvar d = 0; d < int'(N_DEV); d++) begin : g_dev
        localparam int LV = int'(DEV_LVL[d*MAP_FW +: MAP_FW]);
        localparam int PS = int'(DEV_POS[d*MAP_FW +: MAP_FW]);
        assign pick_w[d] = take[LV][PS];
    end

    assign dev_pick = pick_w;

endmodule

// File: rtl/mlvl_arbiter.sv
// Two-stage bus arbiter: fixed priority across levels, daisy chain within.
module mlvl_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N_DEV = 5,
    parameter int unsigned N_LVL = 2,
    // device d level at bits [d*8 +: 8]; default: 0,0,1,1,1
    parameter logic [N_DEV*MAP_FW-1:0] DEV_LVL =
        {8'd1, 8'd1, 8'd1, 8'd0, 8'd0},
    // device d chain position at bits [d*8 +: 8]; default: 0,1,1,0,2
    parameter logic [N_DEV*MAP_FW-1:0] DEV_POS =
        {8'd2, 8'd0, 8'd1, 8'd1, 8'd0}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] dev_req,
    output logic [N_DEV-1:0] dev_gnt,
    output logic [N_LVL-1:0] lvl_gnt,
    output logic             bus_busy
);

    typedef struct packed {
        own_st_e          st;
        logic [N_LVL-1:0] lvl;
        logic [N_DEV-1:0] dev;
    } arb_state_t;

    localparam arb_state_t RESET_ST = '{st: OWN_IDLE, lvl: '0, dev: '0};

    arb_state_t       st_d, st_q;
    logic [N_LVL-1:0] lvl_req;
    logic [N_LVL-1:0] lvl_win;
    logic [N_DEV-1:0] dev_pick;

    mlvl_req_map #(
        .N_DEV   (N_DEV),
        .N_LVL   (N_LVL),
        .DEV_LVL (DEV_LVL)
    ) u_req_map (
        .dev_req (dev_req),
        .lvl_req (lvl_req)
    );

    mlvl_lvl_select #(
        .N_LVL   (N_LVL)
    ) u_lvl_sel (
        .lvl_req (lvl_req),
        .lvl_win (lvl_win)
    );

    mlvl_chain #(
        .N_DEV   (N_DEV),
        .N_LVL   (N_LVL),
        .DEV_LVL (DEV_LVL),
        .DEV_POS (DEV_POS)
    ) u_chain (
        .dev_req  (dev_req),
        .lvl_win  (lvl_win),
        .dev_pick (dev_pick)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            OWN_IDLE: begin
                if (|lvl_req) begin
                    st_d.st  = OWN_HELD;
                    st_d.lvl = lvl_win;
                    st_d.dev = dev_pick;
                end
            end
            OWN_HELD: begin
                // Owner keeps the bus until its own request drops
                if ((dev_req & st_q.dev) == '0) st_d = RESET_ST;
            end
            default: st_d = RESET_ST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign dev_gnt  = st_q.dev;
    assign lvl_gnt  = st_q.lvl;
    assign bus_busy = (st_q.st == OWN_HELD);

endmodule

// File: rtl/mlvl_arbiter_chk.sv
module mlvl_arbiter_chk #(
    parameter int unsigned N_DEV = 5,
    parameter int unsigned N_LVL = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_DEV-1:0] dev_req,
    input logic [N_DEV-1:0] dev_gnt,
    input logic [N_LVL-1:0] lvl_gnt,
    input logic             bus_busy
);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (dev_gnt == '0 && lvl_gnt == '0 && !bus_busy));

    p_idle_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_gnt == '0 && dev_req != '0) |=> (dev_gnt != '0));

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_gnt) && $onehot0(lvl_gnt));

    p_lvl_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dev_gnt) == (|lvl_gnt)) && (bus_busy == (|dev_gnt)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_gnt & dev_req) != '0) |=> ($stable(dev_gnt) && $stable(lvl_gnt)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_gnt != '0 && (dev_gnt & dev_req) == '0) |=> (dev_gnt == '0));

    p_grant_to_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_gnt == '0) |=> ((dev_gnt & ~$past(dev_req)) == '0));

    p_no_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_gnt == '0 && dev_req == '0) |=> (dev_gnt == '0));

endmodule

bind mlvl_arbiter mlvl_arbiter_chk #(
    .N_DEV (N_DEV),
    .N_LVL (N_LVL)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_req  (dev_req),
    .dev_gnt  (dev_gnt),
    .lvl_gnt  (lvl_gnt),
    .bus_busy (bus_busy)
);

// File: tb/sim_mlvl_arbiter.sv
module sim_mlvl_arbiter;

    localparam int unsigned N_DEV = 5;
    localparam int unsigned N_LVL = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_DEV-1:0] dev_req = '0;
    logic [N_DEV-1:0] dev_gnt;
    logic [N_LVL-1:0] lvl_gnt;
    logic             bus_busy;

    int n_vec  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // Expected {lvl_gnt, dev_gnt} per cycle, with the requirement it covers
    logic [N_LVL+N_DEV-1:0] exp_q [$];
    string                  tag_q [$];

    always #2.5 clk = ~clk;

    mlvl_arbiter #(
        .N_DEV (N_DEV),
        .N_LVL (N_LVL)
    ) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_req  (dev_req),
        .dev_gnt  (dev_gnt),
        .lvl_gnt  (lvl_gnt),
        .bus_busy (bus_busy)
    );

    // Driver: apply a request pattern, push what must appear after the edge
    task automatic drive(input logic [N_DEV-1:0] req,
                         input logic [N_LVL-1:0] e_lvl,
                         input logic [N_DEV-1:0] e_dev,
                         input string tag);
        @(negedge clk);
        dev_req = req;
        @(posedge clk);
        exp_q.push_back({e_lvl, e_dev});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N_LVL+N_DEV-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({lvl_gnt, dev_gnt} !== e || bus_busy !== (|e[N_DEV-1:0])) begin
                n_fail++;
                $display("FAIL %s: lvl_gnt=%b dev_gnt=%b busy=%b expected lvl_gnt=%b dev_gnt=%b busy=%b",
                         t, lvl_gnt, dev_gnt, bus_busy,
                         e[N_LVL+N_DEV-1:N_DEV], e[N_DEV-1:0], |e[N_DEV-1:0]);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual cycle=%0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: grants clear during reset
        @(negedge clk);
        dev_req = 5'b11111;
        @(posedge clk);
        exp_q.push_back('0); tag_q.push_back("R1 in reset");
        @(negedge clk);
        dev_req = '0;
        rst_n   = 1'b1;
        @(posedge clk);
        exp_q.push_back('0); tag_q.push_back("R1 after reset");

        drive(5'b00000, 2'b00, 5'b00000, "R9 no request");
        drive(5'b00100, 2'b10, 5'b00100, "R2 lone level-1 requester");
        drive(5'b00101, 2'b10, 5'b00100, "R6 level-0 request does not preempt");
        drive(5'b00001, 2'b00, 5'b00000, "R7 owner release");
        drive(5'b00001, 2'b01, 5'b00001, "R2 grant after idle cycle");
        drive(5'b00000, 2'b00, 5'b00000, "R7 release");
        drive(5'b11111, 2'b01, 5'b00001, "R3 all request, device 0");
        drive(5'b11110, 2'b00, 5'b00000, "R7 release with others waiting");
        drive(5'b11110, 2'b01, 5'b00010, "R4 device 1 next");
        drive(5'b11100, 2'b00, 5'b00000, "R7 release");
        drive(5'b11100, 2'b10, 5'b01000, "R4 device 3 heads level 1");
        drive(5'b10100, 2'b00, 5'b00000, "R7 release");
        drive(5'b10100, 2'b10, 5'b00100, "R4 device 2 before device 4");
        drive(5'b10000, 2'b00, 5'b00000, "R7 release");
        drive(5'b10000, 2'b10, 5'b10000, "R4 device 4 last");
        drive(5'b10000, 2'b10, 5'b10000, "R6 hold");
        drive(5'b11011, 2'b10, 5'b10000, "R6 higher level waits");
        drive(5'b01111, 2'b00, 5'b00000, "R7 release with both levels waiting");
        drive(5'b01111, 2'b01, 5'b00001, "R3 level 0 wins after release");
        drive(5'b01110, 2'b00, 5'b00000, "R7 release");
        drive(5'b01100, 2'b10, 5'b01000, "R8 grant to a requester");
        drive(5'b00000, 2'b00, 5'b00000, "R7 release");
        drive(5'b00000, 2'b00, 5'b00000, "R9 idle stays idle");
        drive(5'b00010, 2'b01, 5'b00010, "R5 level line matches device");

        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule